// File: doc/BRIEF.md
# Banked Framebuffer Window Mapper

This block sits between a host bus and the framebuffer memory of a display controller. It serves the legacy 128 KB graphics aperture. The aperture is split into four 32 KB windows. Each window is routed to one of two programmable bank offsets, the primary or the secondary, and the chosen offset is added to the low 16 bits of the host offset to form a framebuffer byte address.

Software programs the two bank offsets and a mode byte through a small byte-wide register port. The mode byte sets three things: whether the secondary bank has its own offset or sits 32 KB above the primary, whether both offsets are scaled by 64, and which windows go to which bank. Host reads and writes of single bytes are then translated and sent to a one-cycle-latency memory port. Reads that fall past the installed memory return all ones. Writes that fall past it never reach the memory.

Top module: `bankwin_mapper`

## Requirements
- R1: The memory address is host_offset[15:0] plus the bank offset selected for window host_offset[16:15]. The sum is truncated to 22 bits.
- R2: The primary offset is {byte at reg_sel 0, byte at reg_sel 1}, so reg_sel 0 holds the high byte.
- R3: When mode bit 2 is set, the secondary offset is {byte at reg_sel 2, byte at reg_sel 3}. Otherwise it is the primary offset plus 0x8000.
- R4: When mode bit 4 is set, both offsets are shifted left by 6 before the addition.
- R5: When mode bits [7:5] equal 2, windows 0 and 1 use the primary offset and windows 2 and 3 use the secondary offset.
- R6: When mode bits [7:5] equal 3, all four windows use the secondary offset. In every other mode, windows 0 and 2 use the primary offset and windows 1 and 3 use the secondary offset.
- R7: A bank sum that carries past 4 MB wraps around, because the sum is truncated to its low 22 bits.
- R8: The installed size is 512 KB shifted left by cfg_memsize (0: 512 KB, 1: 1 MB, 2: 2 MB, 3: 4 MB). An access whose address is at or above that size does not raise mem_en. Such a read returns 0xFF.
- R9: For an accepted access, mem_en, mem_we, mem_addr and mem_wdata appear one cycle after acceptance. For an accepted read, host_rvalid and host_rdata appear three cycles after acceptance.
- R10: A register write changes the mapping for the next accepted access. An access accepted in the same cycle as the write still uses the old mapping.
- R11: After reset, all register bytes are zero. The mapping is then mode 0, primary offset 0 and implicit secondary offset 0x8000. No strobe or read-valid is active, and both ready outputs are high.
- R12: Register writes with reg_sel values 5, 6 or 7 leave the mapping unchanged. The mode byte is written at reg_sel 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_memsize | input | 2 | Installed memory size code |
| reg_valid | input | 1 | Register write request |
| reg_ready | output | 1 | Register port can accept |
| reg_sel | input | 3 | Register select |
| reg_data | input | 8 | Register byte |
| host_valid | input | 1 | Host access request |
| host_ready | output | 1 | Host port can accept |
| host_we | input | 1 | 1 = write, 0 = read |
| host_offset | input | 17 | Offset in the 128 KB aperture |
| host_wdata | input | 8 | Host write byte |
| host_rvalid | output | 1 | Read data valid |
| host_rdata | output | 8 | Read data |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 22 | Framebuffer byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, one cycle after mem_en |

## Verification
A register write and a host access can be accepted on the same clock edge. When that happens, the access must be translated with the bank values held before the write. The bench drives both requests in one cycle, with the register write changing the very offset that the access selects. It expects the address built from the old offset for that access. A second access follows at once and must show the new offset.

// File: rtl/bankwin_pkg.sv
package bankwin_pkg;

  typedef enum logic [2:0] {
    SEL_PRI_HI = 3'd0,
    SEL_PRI_LO = 3'd1,
    SEL_SEC_HI = 3'd2,
    SEL_SEC_LO = 3'd3,
    SEL_MODE   = 3'd4
  } reg_sel_e;

  localparam logic [2:0] MODE_SPLIT    = 3'd2;
  localparam logic [2:0] MODE_SEC_ONLY = 3'd3;

  localparam int MODE_BIT_SEC_INDEP = 2;
  localparam int MODE_BIT_GRAN      = 4;
  localparam int MODE_FIELD_LSB     = 5;

  typedef struct packed {
    logic       sec_indep;
    logic       gran_x64;
    logic [2:0] bank_mode;
  } mode_cfg_t;

  // Window-to-bank routing: 1 selects the secondary bank.
  function automatic logic win_secondary(input logic [2:0] m, input logic [1:0] w);
    case (m)
      MODE_SPLIT:    return w[1];
      MODE_SEC_ONLY: return 1'b1;
      default:       return w[0];
    endcase
  endfunction

endpackage

// File: rtl/bankwin_regs.sv
module bankwin_regs
  import bankwin_pkg::*;
#(
  parameter int BANK_W     = 16,
  parameter int GRAN_SHIFT = 6,
  parameter int BASE_W     = BANK_W + 1 + GRAN_SHIFT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [7:0]        wr_data,
  output logic [BASE_W-1:0] pri_base,
  output logic [BASE_W-1:0] sec_base,
  output logic [2:0]        bank_mode
);

  localparam int HALF_W = BANK_W / 2;
  localparam int RAW_W  = BANK_W + 1;
  localparam logic [RAW_W-1:0] IMPLICIT_STEP = RAW_W'(1) << (BANK_W - 1);

  logic [HALF_W-1:0] pri_hi_q, pri_lo_q, sec_hi_q, sec_lo_q;
  mode_cfg_t         mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pri_hi_q <= '0;
      pri_lo_q <= '0;
      sec_hi_q <= '0;
      sec_lo_q <= '0;
      mode_q   <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_PRI_HI: pri_hi_q <= wr_data[HALF_W-1:0];
        SEL_PRI_LO: pri_lo_q <= wr_data[HALF_W-1:0];
        SEL_SEC_HI: sec_hi_q <= wr_data[HALF_W-1:0];
        SEL_SEC_LO: sec_lo_q <= wr_data[HALF_W-1:0];
        SEL_MODE: begin
          mode_q.sec_indep <= wr_data[MODE_BIT_SEC_INDEP];
          mode_q.gran_x64  <= wr_data[MODE_BIT_GRAN];
          mode_q.bank_mode <= wr_data[MODE_FIELD_LSB +: 3];
        end
        default: ;
      endcase
    end
  end

  logic [RAW_W-1:0] pri_raw, sec_raw;

  always_comb begin
    pri_raw = RAW_W'({pri_hi_q, pri_lo_q});
    if (mode_q.sec_indep) sec_raw = RAW_W'({sec_hi_q, sec_lo_q});
    else                  sec_raw = pri_raw + IMPLICIT_STEP;
  end

  always_comb begin
    if (mode_q.gran_x64) begin
      pri_base = BASE_W'(pri_raw) << GRAN_SHIFT;
      sec_base = BASE_W'(sec_raw) << GRAN_SHIFT;
    end else begin
      pri_base = BASE_W'(pri_raw);
      sec_base = BASE_W'(sec_raw);
    end
  end

  assign bank_mode = mode_q.bank_mode;

endmodule

// File: rtl/bankwin_route.sv
module bankwin_route
  import bankwin_pkg::*;
#(
  parameter int AP_W         = 17,
  parameter int BASE_W       = 23,
  parameter int MIN_MEM_LOG2 = 19,
  parameter int SIZE_W       = 2,
  parameter int DEC_AW       = MIN_MEM_LOG2 + (1 << SIZE_W) - 1
) (
  input  logic [AP_W-1:0]   offset,
  input  logic [BASE_W-1:0] pri_base,
  input  logic [BASE_W-1:0] sec_base,
  input  logic [2:0]        bank_mode,
  input  logic [SIZE_W-1:0] cfg_memsize,
  output logic [DEC_AW-1:0] addr,
  output logic              in_range
);

  localparam int NWIN  = 4;
  localparam int LO_W  = AP_W - 2;
  localparam int SUM_W = (BASE_W > LO_W ? BASE_W : LO_W) + 1;

  logic [NWIN-1:0] use_sec;

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    assign use_sec[w] = win_secondary(bank_mode, 2'(w));
  end

  logic [1:0]        win;
  logic [BASE_W-1:0] base;
  logic [SUM_W-1:0]  sum;
  logic [DEC_AW-1:0] over;
  int unsigned       lim_log2;

  always_comb begin
    win      = offset[AP_W-1 -: 2];
    base     = use_sec[win] ? sec_base : pri_base;
    sum      = SUM_W'(offset[AP_W-2:0] & {(AP_W-1){1'b1}}) + SUM_W'(base);
    addr     = sum[DEC_AW-1:0];
    lim_log2 = MIN_MEM_LOG2 + 32'(cfg_memsize);
    over     = addr >> lim_log2;
    in_range = (over == '0);
  end

endmodule

// File: rtl/bankwin_port.sv
module bankwin_port #(
  parameter int DEC_AW       = 22,
  parameter int DATA_W       = 8,
  parameter int MIN_MEM_LOG2 = 19,
  parameter int SIZE_W       = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SIZE_W-1:0] cfg_memsize,
  input  logic              host_valid,
  input  logic              host_we,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic [DEC_AW-1:0] addr,
  input  logic              in_range,
  output logic              ready,
  output logic              host_rvalid,
  output logic [DATA_W-1:0] host_rdata,
  output logic              mem_en,
  output logic              mem_we,
  output logic [DEC_AW-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);

  logic              accept;
  logic [DEC_AW-1:0] size_mask;
  logic              rd_mem_q, rd_oor_q, rd_mem_q2, rd_oor_q2;

  assign accept    = host_valid & ready;
  assign size_mask = ~(~DEC_AW'(0) << (MIN_MEM_LOG2 + 32'(cfg_memsize)));

  always_ff @(posedge clk) begin
    if (rst) ready <= 1'b0;
    else     ready <= 1'b1;
  end

  // Issue stage
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_en    <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      rd_mem_q  <= 1'b0;
      rd_oor_q  <= 1'b0;
    end else begin
      mem_en    <= accept & in_range;
      mem_we    <= accept & in_range & host_we;
      mem_addr  <= addr & size_mask;
      mem_wdata <= host_wdata;
      rd_mem_q  <= accept & in_range & ~host_we;
      rd_oor_q  <= accept & ~in_range & ~host_we;
    end
  end

  // Memory latency stage
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_mem_q2 <= 1'b0;
      rd_oor_q2 <= 1'b0;
    end else begin
      rd_mem_q2 <= rd_mem_q;
      rd_oor_q2 <= rd_oor_q;
    end
  end

  // Return stage
  always_ff @(posedge clk) begin
    if (rst) begin
      host_rvalid <= 1'b0;
      host_rdata  <= '0;
    end else begin
      host_rvalid <= rd_mem_q2 | rd_oor_q2;
      if (rd_oor_q2)      host_rdata <= '1;
      else if (rd_mem_q2) host_rdata <= mem_rdata;
    end
  end

endmodule

// File: rtl/bankwin_mapper.sv
module bankwin_mapper #(
  parameter int AP_W         = 17,
  parameter int DATA_W       = 8,
  parameter int BANK_W       = 16,
  parameter int GRAN_SHIFT   = 6,
  parameter int MIN_MEM_LOG2 = 19,
  parameter int SIZE_W       = 2,
  parameter int DEC_AW       = MIN_MEM_LOG2 + (1 << SIZE_W) - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SIZE_W-1:0] cfg_memsize,
  input  logic              reg_valid,
  output logic              reg_ready,
  input  logic [2:0]        reg_sel,
  input  logic [7:0]        reg_data,
  input  logic              host_valid,
  output logic              host_ready,
  input  logic              host_we,
  input  logic [AP_W-1:0]   host_offset,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_rvalid,
  output logic [DATA_W-1:0] host_rdata,
  output logic              mem_en,
  output logic              mem_we,
  output logic [DEC_AW-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);

  localparam int BASE_W = BANK_W + 1 + GRAN_SHIFT;

  logic [BASE_W-1:0] pri_base, sec_base;
  logic [2:0]        bank_mode;
  logic [DEC_AW-1:0] xl_addr;
  logic              xl_in_range;
  logic              port_ready;

  assign reg_ready  = port_ready;
  assign host_ready = port_ready;

  bankwin_regs #(
    .BANK_W(BANK_W), .GRAN_SHIFT(GRAN_SHIFT), .BASE_W(BASE_W)
  ) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(reg_valid & port_ready), .wr_sel(reg_sel), .wr_data(reg_data),
    .pri_base(pri_base), .sec_base(sec_base), .bank_mode(bank_mode)
  );

  bankwin_route #(
    .AP_W(AP_W), .BASE_W(BASE_W), .MIN_MEM_LOG2(MIN_MEM_LOG2),
    .SIZE_W(SIZE_W), .DEC_AW(DEC_AW)
  ) u_route (
    .offset(host_offset), .pri_base(pri_base), .sec_base(sec_base),
    .bank_mode(bank_mode), .cfg_memsize(cfg_memsize),
    .addr(xl_addr), .in_range(xl_in_range)
  );

  bankwin_port #(
    .DEC_AW(DEC_AW), .DATA_W(DATA_W), .MIN_MEM_LOG2(MIN_MEM_LOG2), .SIZE_W(SIZE_W)
  ) u_port (
    .clk(clk), .rst(rst), .cfg_memsize(cfg_memsize),
    .host_valid(host_valid), .host_we(host_we), .host_wdata(host_wdata),
    .addr(xl_addr), .in_range(xl_in_range), .ready(port_ready),
    .host_rvalid(host_rvalid), .host_rdata(host_rdata),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

endmodule

// File: rtl/bankwin_mapper_chk.sv
module bankwin_mapper_chk #(
  parameter int DATA_W       = 8,
  parameter int MIN_MEM_LOG2 = 19,
  parameter int SIZE_W       = 2,
  parameter int DEC_AW       = MIN_MEM_LOG2 + (1 << SIZE_W) - 1
) (
  input logic              clk,
  input logic              rst,
  input logic [SIZE_W-1:0] cfg_memsize,
  input logic              host_valid,
  input logic              host_ready,
  input logic              host_we,
  input logic [DATA_W-1:0] host_wdata,
  input logic              host_rvalid,
  input logic              mem_en,
  input logic              mem_we,
  input logic [DEC_AW-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata
);

  logic acc_rd;
  assign acc_rd = host_valid & host_ready & ~host_we;

  // R9
  strobe_from_accept_chk: assert property (@(posedge clk) disable iff (rst)
    mem_en |-> $past(host_valid & host_ready));

  // R9
  write_payload_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_en & mem_we) |-> ($past(host_we) && mem_wdata == $past(host_wdata)));

  // R9
  read_return_chk: assert property (@(posedge clk) disable iff (rst)
    acc_rd |-> ##3 host_rvalid);

  // R9
  rvalid_source_chk: assert property (@(posedge clk) disable iff (rst)
    host_rvalid |-> $past(acc_rd, 3));

  // R8
  installed_range_chk: assert property (@(posedge clk) disable iff (rst)
    mem_en |-> ((mem_addr >> (MIN_MEM_LOG2 + 32'(cfg_memsize))) == '0));

endmodule

bind bankwin_mapper bankwin_mapper_chk u_chk (
  .clk(clk), .rst(rst), .cfg_memsize(cfg_memsize),
  .host_valid(host_valid), .host_ready(host_ready), .host_we(host_we),
  .host_wdata(host_wdata), .host_rvalid(host_rvalid),
  .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
);

// File: tb/bankwin_mapper_test.sv
`timescale 1ns/1ps
module bankwin_mapper_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  cfg_memsize = 2'd3;
  logic        reg_valid = 1'b0;
  logic        reg_ready;
  logic [2:0]  reg_sel = '0;
  logic [7:0]  reg_data = '0;
  logic        host_valid = 1'b0;
  logic        host_ready;
  logic        host_we = 1'b0;
  logic [16:0] host_offset = '0;
  logic [7:0]  host_wdata = '0;
  logic        host_rvalid;
  logic [7:0]  host_rdata;
  logic        mem_en, mem_we;
  logic [21:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  bankwin_mapper uut (.*);

  function automatic logic [7:0] mem_pat(input logic [21:0] a);
    return a[7:0] ^ a[15:8] ^ {2'b00, a[21:16]} ^ 8'h5A;
  endfunction

  always @(posedge clk) mem_rdata <= (mem_en && !mem_we) ? mem_pat(mem_addr) : 8'h00;

  // Bench model of the register bytes
  int m_ph = 0, m_pl = 0, m_sh = 0, m_sl = 0, m_mode = 0;

  function automatic void model_wr(input int sel, input int d);
    case (sel)
      0: m_ph = d;
      1: m_pl = d;
      2: m_sh = d;
      3: m_sl = d;
      4: m_mode = d;
      default: ;
    endcase
  endfunction

  function automatic longint exp_addr(input int off);
    longint pri, sec, base, s;
    int win, md;
    bit use_sec;
    pri = longint'(m_ph) * 256 + m_pl;
    sec = ((m_mode >> 2) & 1) != 0 ? longint'(m_sh) * 256 + m_sl : pri + 32768;
    if (((m_mode >> 4) & 1) != 0) begin
      pri = pri * 64;
      sec = sec * 64;
    end
    win = (off >> 15) & 3;
    md = (m_mode >> 5) & 7;
    if (md == 2)      use_sec = (win >= 2);
    else if (md == 3) use_sec = 1'b1;
    else              use_sec = (win % 2) == 1;
    base = use_sec ? sec : pri;
    s = (off & 16'hFFFF) + base;
    return s % (longint'(1) << 22);
  endfunction

  function automatic bit exp_in(input longint a);
    return a < (longint'(524288) << cfg_memsize);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  task automatic reg_wr(input int sel, input int d);
    @(negedge clk);
    reg_valid = 1'b1;
    reg_sel = 3'(sel);
    reg_data = 8'(d);
    @(negedge clk);
    reg_valid = 1'b0;
    model_wr(sel, d);
  endtask

  // One access; drive at a negedge and check strobes after the next edge
  task automatic access(input bit we, input int off, input int wd, input string req);
    longint ea;
    bit inr;
    ea = exp_addr(off);
    inr = exp_in(ea);
    @(negedge clk);
    host_valid = 1'b1;
    host_we = we;
    host_offset = 17'(off);
    host_wdata = 8'(wd);
    @(negedge clk);
    host_valid = 1'b0;
    chk(mem_en == inr, req, mem_en, inr);
    if (inr) begin
      chk(mem_addr == 22'(ea), req, mem_addr, ea);
      chk(mem_we == we, req, mem_we, we);
      if (we) chk(mem_wdata == 8'(wd), req, mem_wdata, wd);
    end
    @(negedge clk);
    @(negedge clk);
    if (!we) begin
      chk(host_rvalid == 1'b1, {req, " rvalid"}, host_rvalid, 1);
      if (inr) chk(host_rdata == mem_pat(22'(ea)), {req, " rdata"}, host_rdata, mem_pat(22'(ea)));
      else     chk(host_rdata == 8'hFF, {req, " oor rdata"}, host_rdata, 8'hFF);
    end else begin
      chk(host_rvalid == 1'b0, {req, " no rvalid"}, host_rvalid, 0);
    end
  endtask

  initial begin
    #(8 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    longint ea;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk);
    // R11 reset state
    chk(host_ready && reg_ready, "R11 ready", {host_ready, reg_ready}, 3);
    chk(!mem_en && !host_rvalid, "R11 idle", {mem_en, host_rvalid}, 0);
    access(0, 17'h08000, 0, "R11 implicit secondary");
    chk(exp_addr(17'h08000) == 64'h10000, "R11 model", exp_addr(17'h08000), 64'h10000);

    // R2 / R3 implicit secondary
    reg_wr(0, 8'h12); reg_wr(1, 8'h34);
    access(0, 17'h00010, 0, "R2 primary bytes");
    access(0, 17'h08001, 0, "R3 implicit secondary");
    // R4 with R3 implicit and window 3
    reg_wr(4, 8'h10);
    access(1, 17'h18010, 8'hA5, "R4 shift window3");
    access(0, 17'h00005, 0, "R4 shift window0");
    // R5 split mode, independent secondary
    reg_wr(0, 8'h00); reg_wr(1, 8'h12);
    reg_wr(2, 8'h01); reg_wr(3, 8'h00);
    reg_wr(4, 8'h44);
    access(0, 17'h0A000, 0, "R5 window1 primary");
    access(0, 17'h12345, 0, "R5 window2 secondary");
    // R6 secondary only, then interleaved
    reg_wr(4, 8'h64);
    access(0, 17'h00010, 0, "R6 window0 secondary");
    reg_wr(4, 8'hE4);
    access(0, 17'h10010, 0, "R6 other mode window2 primary");
    access(0, 17'h18010, 0, "R6 other mode window3 secondary");
    // R7 wrap past 4 MB
    reg_wr(4, 8'h10); reg_wr(0, 8'hFF); reg_wr(1, 8'hFF);
    access(0, 17'h00100, 0, "R7 wrap");
    chk(exp_addr(17'h00100) == 64'hC0, "R7 model", exp_addr(17'h00100), 64'hC0);
    // R8 installed size
    cfg_memsize = 2'd0;
    reg_wr(0, 8'h20); reg_wr(1, 8'h00);
    access(0, 17'h00000, 0, "R8 oor read");
    access(1, 17'h00000, 8'h77, "R8 oor write dropped");
    cfg_memsize = 2'd1;
    access(0, 17'h00000, 0, "R8 1MB in range");
    cfg_memsize = 2'd3;
    // R12 ignored selects
    reg_wr(5, 8'hFF); reg_wr(6, 8'hFF); reg_wr(7, 8'hFF);
    access(0, 17'h00003, 0, "R12 ignored selects");
    // R10 same-cycle register write and access
    reg_wr(4, 8'h00); reg_wr(0, 8'h00); reg_wr(1, 8'h40);
    ea = exp_addr(17'h00020);
    @(negedge clk);
    reg_valid = 1'b1; reg_sel = 3'd1; reg_data = 8'h80;
    host_valid = 1'b1; host_we = 1'b0; host_offset = 17'h00020;
    @(negedge clk);
    reg_valid = 1'b0; host_valid = 1'b0;
    chk(mem_en && mem_addr == 22'(ea), "R10 old mapping", mem_addr, ea);
    model_wr(1, 8'h80);
    @(negedge clk); @(negedge clk);
    access(0, 17'h00020, 0, "R10 new mapping");
    // Random mix for R1
    for (int i = 0; i < 300; i++) begin
      int r;
      r = int'($urandom % 10);
      if (r < 3) reg_wr(int'($urandom % 8), int'($urandom % 256));
      else if (r == 3) cfg_memsize = 2'($urandom);
      else access(bit'($urandom), int'($urandom % 131072), int'($urandom % 256), "R1 random");
    end
    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule